// File: doc/BRIEF.md
# SD SPI Data Block Receiver

This block takes over the SPI byte stream once a card has accepted a read command, and collects one or more data blocks of a fixed size. Before each block it reads filler bytes until a start token appears. It then passes the payload bytes to a valid/ready stream and reads the two check bytes that end the block. It computes a CRC16-CCITT over the payload as the bytes arrive, and compares it with the two check bytes unless checking is turned off. The block repeats this for the number of blocks it was given. It stops at the first fault and reports one of four status codes.

The block never drives the serial lines itself. It asks an external SPI shifter for one byte exchange at a time, and the shifter sends 0xFF while it captures the card's byte. Software or a command engine loads the block count, the block size and the check enable, then pulses `start`. The result is valid in the cycle that `done` pulses.

Payload stream rules: `m_data` and `m_last` are valid while `m_valid` is high. A byte moves on a clock edge where both `m_valid` and `m_ready` are high. While `m_ready` is low, the byte and its flag stay unchanged. The block asks for the next payload byte from the card only after the output register has emptied, so back-pressure on the stream throttles the SPI link directly and no byte is ever dropped.

Top module: `sdrx_block_rx`

## Requirements
- R1: After reset, `busy`, `done`, `m_valid` and `xch_req` are 0, and `status` is 0.
- R2: Before each block, bytes equal to 0xFF are consumed and discarded. The first byte of any other value is taken as the token.
- R3: After a 0xFE token, exactly block-size payload bytes are sent on the stream in arrival order, and `m_last` is 1 only on the final byte of the block. The next two bytes are read as the check value, high byte first, and are not sent on the stream.
- R4: A block size of one byte is handled: the single payload byte carries `m_last`, and the transfer then completes with status 0.
- R5: With checking enabled, the CRC16-CCITT over the payload (polynomial 0x1021, initial value 0, data taken MSB first) is compared with the check value. On a mismatch the transfer ends with status 2, and no byte of later blocks is requested. On a match it continues, or ends with status 0 after the last block.
- R6: A token byte other than 0xFF or 0xFE ends the transfer with status 1, and no payload byte is sent.
- R7: With a limit of L, if the L-th consecutive 0xFF byte of a hunt is read, the transfer ends with status 3 and no further byte is requested. A token that arrives after L-1 filler bytes is accepted.
- R8: With checking disabled, the two check bytes are read and discarded, and a wrong check value still gives status 0.
- R9: For a block count of N, the hunt, payload and check phases run N times. The filler limit applies afresh to each block.
- R10: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold. No payload byte is lost or repeated under any pattern of `m_ready`.
- R11: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse, issued only after every payload byte has left the stream. A `start` pulse while `busy` is high is ignored.
- R12: Only one byte exchange is outstanding at a time. `xch_req` stays high until `xch_rvalid` and falls in the next cycle. The total number of exchanges equals the bytes the rules above call for, with none beyond the point of completion or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| blk_count | input | CNT_W | Number of blocks, at least 1 |
| blk_size | input | SIZE_W | Payload bytes per block, at least 1 |
| crc_check_en | input | 1 | 1 = compare the check bytes with the computed CRC |
| xch_req | output | 1 | Request one byte exchange from the SPI shifter |
| xch_rvalid | input | 1 | One-cycle pulse: exchanged byte is on `xch_rdata` |
| xch_rdata | input | 8 | Byte received from the card |
| m_valid | output | 1 | Payload byte valid |
| m_ready | input | 1 | Downstream accepts the payload byte |
| m_data | output | 8 | Payload byte |
| m_last | output | 1 | Final payload byte of the current block |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 bad token, 2 CRC mismatch, 3 token timeout; valid at `done` |

## Verification
The assertions assume that the shifter raises `xch_rvalid` only while `xch_req` is high, for exactly one cycle per exchange. They also assume that `start` arrives with a block count and a block size of at least one. The bench's shifter model waits until it sees a request, waits a latency of zero to two cycles, and then returns exactly one byte as a one-cycle pulse. Every transfer it starts uses sizes and counts of one or more. The payload sink varies `m_ready` across always-ready, mostly-ready and sparse patterns, so that the hold property and the fetch throttling are both exercised.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;

  typedef enum logic [1:0] {
    RX_OK        = 2'd0,
    RX_BAD_TOKEN = 2'd1,
    RX_BAD_CRC   = 2'd2,
    RX_TIMEOUT   = 2'd3
  } rx_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HUNT,
    S_DATA,
    S_CRC_HI,
    S_CRC_LO,
    S_DRAIN
  } rx_state_e;

  localparam logic [7:0]  FILL_BYTE   = 8'hFF;
  localparam logic [7:0]  START_TOKEN = 8'hFE;
  localparam logic [15:0] CRC_POLY    = 16'h1021;

endpackage

// File: rtl/sdrx_crc16.sv
module sdrx_crc16 #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  function automatic logic [15:0] step_byte(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= step_byte(crc, din);
  end

endmodule

// File: rtl/sdrx_hunt_timer.sv
module sdrx_hunt_timer #(
  parameter int unsigned LIMIT = 3000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic last_slot
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign last_slot = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sdrx_xch_port.sv
module sdrx_xch_port (
  input  logic clk,
  input  logic rst_n,
  input  logic need,
  input  logic rvalid,
  output logic req,
  output logic got
);

  assign got = req & rvalid;

  always_ff @(posedge clk) begin
    if (!rst_n)            req <= 1'b0;
    else if (got)          req <= 1'b0;
    else if (!req && need) req <= 1'b1;
  end

endmodule

// File: rtl/sdrx_out_stage.sv
module sdrx_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         ld_last,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         last
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      last  <= 1'b0;
    end else begin
      if (valid && ready) valid <= 1'b0;
      if (load) begin
        valid <= 1'b1;
        data  <= ld_data;
        last  <= ld_last;
      end
    end
  end

endmodule

// File: rtl/sdrx_block_rx.sv
module sdrx_block_rx
  import sdrx_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SIZE_W     = 12,
  parameter int unsigned HUNT_LIMIT = 3000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  blk_count,
  input  logic [SIZE_W-1:0] blk_size,
  input  logic              crc_check_en,
  output logic              xch_req,
  input  logic              xch_rvalid,
  input  logic [7:0]        xch_rdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [7:0]        m_data,
  output logic              m_last,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status
);

  localparam logic [SIZE_W-1:0] SIZE_ONE = SIZE_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  rx_state_e         state_q;
  rx_status_e        status_q;
  logic [CNT_W-1:0]  left_q;
  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] idx_q;
  logic              chk_q;
  logic [7:0]        crc_hi_q;
  logic              done_q;

  logic        need, got, load, out_empty, last_byte;
  logic        hunt_clr, hunt_tick, hunt_last;
  logic        crc_clr;
  logic [15:0] crc_val;

  // Fetch control: a payload byte is fetched only into an empty output register
  assign out_empty = ~m_valid;
  assign last_byte = (idx_q == size_q - SIZE_ONE);
  assign need      = (state_q == S_HUNT) || (state_q == S_CRC_HI) ||
                     (state_q == S_CRC_LO) || ((state_q == S_DATA) && out_empty);
  assign load      = got && (state_q == S_DATA);
  assign crc_clr   = got && (state_q == S_HUNT) && (xch_rdata == START_TOKEN);
  assign hunt_tick = got && (state_q == S_HUNT) && (xch_rdata == FILL_BYTE);
  assign hunt_clr  = ((state_q == S_IDLE) && start) || (got && (state_q == S_CRC_LO));

  sdrx_xch_port u_port (
    .clk    (clk),
    .rst_n  (rst_n),
    .need   (need),
    .rvalid (xch_rvalid),
    .req    (xch_req),
    .got    (got)
  );

  sdrx_hunt_timer #(.LIMIT(HUNT_LIMIT)) u_hunt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (hunt_clr),
    .tick      (hunt_tick),
    .last_slot (hunt_last)
  );

  sdrx_crc16 #(.POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (load),
    .din   (xch_rdata),
    .crc   (crc_val)
  );

  sdrx_out_stage #(.W(8)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .ld_data (xch_rdata),
    .ld_last (last_byte),
    .ready   (m_ready),
    .valid   (m_valid),
    .data    (m_data),
    .last    (m_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      status_q <= RX_OK;
      left_q   <= '0;
      size_q   <= '0;
      idx_q    <= '0;
      chk_q    <= 1'b0;
      crc_hi_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            left_q   <= blk_count;
            size_q   <= blk_size;
            chk_q    <= crc_check_en;
            status_q <= RX_OK;
            state_q  <= S_HUNT;
          end
        end
        S_HUNT: begin
          if (got) begin
            if (xch_rdata == FILL_BYTE) begin
              if (hunt_last) begin
                status_q <= RX_TIMEOUT;
                state_q  <= S_DRAIN;
              end
            end else if (xch_rdata == START_TOKEN) begin
              idx_q   <= '0;
              state_q <= S_DATA;
            end else begin
              status_q <= RX_BAD_TOKEN;
              state_q  <= S_DRAIN;
            end
          end
        end
        S_DATA: begin
          if (got) begin
            idx_q <= idx_q + SIZE_ONE;
            if (last_byte) state_q <= S_CRC_HI;
          end
        end
        S_CRC_HI: begin
          if (got) begin
            crc_hi_q <= xch_rdata;
            state_q  <= S_CRC_LO;
          end
        end
        S_CRC_LO: begin
          if (got) begin
            if (chk_q && ({crc_hi_q, xch_rdata} != crc_val)) begin
              status_q <= RX_BAD_CRC;
              state_q  <= S_DRAIN;
            end else if (left_q == CNT_ONE) begin
              state_q <= S_DRAIN;
            end else begin
              left_q  <= left_q - CNT_ONE;
              state_q <= S_HUNT;
            end
          end
        end
        S_DRAIN: begin
          if (out_empty) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != S_IDLE);
  assign done   = done_q;
  assign status = status_q;

endmodule

// File: rtl/sdrx_block_rx_chk.sv
module sdrx_block_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xch_req,
  input logic       xch_rvalid,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_last,
  input logic       busy,
  input logic       done
);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xch_req && !xch_rvalid |=> xch_req);

  assert_req_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xch_req && xch_rvalid |=> !xch_req);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !xch_req);

  assert_stream_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));

  assert_valid_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> busy);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_drained_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !m_valid && !busy);

endmodule

bind sdrx_block_rx sdrx_block_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xch_req    (xch_req),
  .xch_rvalid (xch_rvalid),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_data     (m_data),
  .m_last     (m_last),
  .busy       (busy),
  .done       (done)
);

// File: tb/sim_sdrx_block_rx.sv
`timescale 1ns/1ps
module sim_sdrx_block_rx;
  localparam int CW  = 4;
  localparam int SW  = 8;
  localparam int LIM = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] blk_count = '0;
  logic [SW-1:0] blk_size = '0;
  logic          crc_check_en = 1'b0;
  logic          xch_req;
  logic          xch_rvalid = 1'b0;
  logic [7:0]    xch_rdata = 8'h00;
  logic          m_valid;
  logic          m_ready = 1'b0;
  logic [7:0]    m_data;
  logic          m_last;
  logic          busy;
  logic          done;
  logic [1:0]    status;

  always #2 clk = ~clk;

  sdrx_block_rx #(.CNT_W(CW), .SIZE_W(SW), .HUNT_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count),
    .blk_size(blk_size), .crc_check_en(crc_check_en),
    .xch_req(xch_req), .xch_rvalid(xch_rvalid), .xch_rdata(xch_rdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .busy(busy), .done(done), .status(status)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int ready_mode = 0;
  int consumed = 0;
  int pushed = 0;
  int done_cnt = 0;
  logic       done_seen = 1'b0;
  logic [1:0] got_status = 2'd0;
  logic [7:0] card_q[$];
  logic [8:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [15:0] c_in, input logic [7:0] b);
    logic [15:0] c;
    c = c_in ^ {b, 8'h00};
    for (int k = 0; k < 8; k++)
      c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    return c;
  endfunction

  // Driver: queues the card's bytes and the payload the stream must show
  task automatic card_block(input int size, input int lead, input logic [7:0] tok,
                            input bit bad_crc, input bit expect_out, input int seed);
    logic [15:0] c;
    logic [7:0]  b;
    c = 16'h0000;
    for (int i = 0; i < lead; i++) card_q.push_back(8'hFF);
    card_q.push_back(tok);
    for (int i = 0; i < size; i++) begin
      b = 8'(seed * 29 + i * 7 + 3);
      card_q.push_back(b);
      c = crc_ref(c, b);
      if (expect_out) exp_q.push_back({(i == size - 1), b});
    end
    if (bad_crc) c = c ^ 16'h0100;
    card_q.push_back(c[15:8]);
    card_q.push_back(c[7:0]);
    pushed += lead + 1 + size + 2;
  endtask

  task automatic clear_tb();
    card_q.delete();
    exp_q.delete();
    pushed = 0;
    consumed = 0;
    done_cnt = 0;
  endtask

  task automatic run(input int count, input int size, input bit crc_en,
                     input logic [1:0] exp_st, input int leftover,
                     input bit mid_start, input string tag);
    @(negedge clk);
    blk_count = CW'(count);
    blk_size = SW'(size);
    crc_check_en = crc_en;
    done_seen = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_start) begin
      repeat (15) @(negedge clk);
      check(busy == 1'b1, "R11", "busy during transfer", busy, 1);
      blk_count = CW'(1);
      blk_size = SW'(1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done_seen) @(negedge clk);
    repeat (3) @(negedge clk);
    check(got_status == exp_st, tag, "status", got_status, exp_st);
    check(exp_q.size() == 0, tag, "payload bytes missing", exp_q.size(), 0);
    check(card_q.size() == leftover && consumed == pushed - leftover, "R12",
          "bytes exchanged", consumed, pushed - leftover);
    check(done_cnt == 1, "R11", "done pulses", done_cnt, 1);
    check(!busy && !xch_req && !m_valid, "R11", "idle after done",
          {busy, xch_req, m_valid}, 0);
    clear_tb();
  endtask

  // SPI shifter model: one byte per request after 0..2 cycles
  initial begin
    forever begin
      @(negedge clk);
      if (xch_req) begin
        repeat (consumed % 3) @(negedge clk);
        xch_rdata = (card_q.size() != 0) ? card_q.pop_front() : 8'hFF;
        consumed++;
        xch_rvalid = 1'b1;
        @(negedge clk);
        xch_rvalid = 1'b0;
      end
    end
  end

  // Monitor: sets ready, then compares each byte that will move at the next edge
  initial begin
    logic [8:0] e;
    forever begin
      @(negedge clk);
      cyc++;
      case (ready_mode)
        0:       m_ready = 1'b1;
        1:       m_ready = (cyc % 3 != 0);
        default: m_ready = (cyc % 4 == 1);
      endcase
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected payload byte", m_data, 0);
        end else begin
          e = exp_q.pop_front();
          check(m_data == e[7:0], "R3", "payload byte", m_data, e[7:0]);
          check(m_last == e[8], "R3", "last flag", m_last, e[8]);
        end
      end
      if (done) begin
        done_seen = 1'b1;
        got_status = status;
        done_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!busy && !done && !m_valid && !xch_req && status == 2'd0, "R1",
          "reset outputs", {busy, done, m_valid, xch_req, status}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: filler bytes before token
    ready_mode = 0;
    card_block(8, 3, 8'hFE, 0, 1, 1);
    run(1, 8, 1, 2'd0, 0, 0, "R2");

    // R9: three blocks, fresh filler limit per block, sparse ready
    ready_mode = 2;
    card_block(16, 0, 8'hFE, 0, 1, 2);
    card_block(16, 5, 8'hFE, 0, 1, 3);
    card_block(16, LIM - 1, 8'hFE, 0, 1, 4);
    run(3, 16, 1, 2'd0, 0, 0, "R9");

    // R4: one-byte block
    ready_mode = 1;
    card_block(1, 0, 8'hFE, 0, 1, 5);
    run(1, 1, 1, 2'd0, 0, 0, "R4");

    // R5: mismatch on block 2 of 3; block 3 must stay unread
    ready_mode = 0;
    card_block(8, 1, 8'hFE, 0, 1, 6);
    card_block(8, 2, 8'hFE, 1, 1, 7);
    card_block(8, 2, 8'hFE, 0, 0, 8);
    run(3, 8, 1, 2'd2, 13, 0, "R5");

    // R8: same stream with checking disabled
    ready_mode = 1;
    card_block(8, 1, 8'hFE, 0, 1, 6);
    card_block(8, 2, 8'hFE, 1, 1, 7);
    card_block(8, 2, 8'hFE, 0, 1, 8);
    run(3, 8, 0, 2'd0, 0, 0, "R8");

    // R6: bad token, nothing streamed
    ready_mode = 0;
    card_block(4, 2, 8'hFC, 0, 0, 9);
    run(1, 4, 1, 2'd1, 6, 0, "R6");

    // R7: limit reached exactly
    card_block(4, LIM, 8'hFE, 0, 0, 10);
    run(1, 4, 1, 2'd3, 7, 0, "R7");

    // R7: token one byte before the limit
    card_block(8, LIM - 1, 8'hFE, 0, 1, 11);
    run(1, 8, 1, 2'd0, 0, 0, "R7");

    // R10: heavy back-pressure
    ready_mode = 2;
    card_block(8, 2, 8'hFE, 0, 1, 12);
    card_block(8, 0, 8'hFE, 0, 1, 13);
    run(2, 8, 1, 2'd0, 0, 0, "R10");

    // R11: start while busy is ignored
    ready_mode = 1;
    card_block(16, 3, 8'hFE, 0, 1, 14);
    run(1, 16, 1, 2'd0, 0, 1, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule